// File: doc/BRIEF.md
# OSD Layer Scanout Unpacker

This block takes the framebuffer of one graphics overlay layer as a stream of 32-bit words and turns it into a stream of 24-bit pixels. The stored pixel layout is chosen by configuration: 16-bit 5:6:5 RGB, tightly packed 24-bit RGB, or 32-bit RGB with an unused top byte. Each pixel is widened to 8 bits per channel. An optional colour stage then converts it to studio-range Y/Cb/Cr. Downstream logic can stall the pixel output, and the stall propagates back to the word source.

The block also produces the start address of each framebuffer line that the memory side must fetch. It emits one address per horizontal sync. In interlaced mode it skips the lines of the other field. All layer settings are first written into a pending copy and move into the working copy only at vertical sync, so a frame never mixes two configurations. Vertical sync also discards any partly assembled pixel bytes and any pixel waiting at the output.

Top module: `osd_scanout`

## Requirements
- R1: After reset, `pix_valid`, `word_ready` and `fetch_req` are all low, and the working configuration has the layer disabled.
- R2: Register writes change only the pending configuration; the working configuration loads on a cycle with `vsync` high; a write in the same cycle as `vsync` takes effect at the following vsync; if a register is written several times between vsyncs, only the last value is used. Register map: address 0 is control (bit 0 enable, bit 1 interlaced, bit 2 colour conversion, bits 5:4 format), address 1 is base byte address, address 2 is line stride in bytes, and address 3 is ignored.
- R3: Format 0 (5:6:5) yields two pixels per word, bits 15:0 first. Each channel is widened by copying its top bits into the freed low bits (R 15:11, G 10:5, B 4:0).
- R4: Format 1 (packed 24-bit) treats the words as a byte stream, lowest byte first, with each pixel taking bytes B, G, R in that order. Pixels may straddle words, so three words yield four pixels.
- R5: Format 2, and format 3 too, yield one pixel per word from bits 23:0 (R 23:16, G 15:8, B 7:0); bits 31:24 have no effect.
- R6: With conversion on, the output is {Y,Cb,Cr} with Y=((66R+129G+25B+128)>>8)+16, Cb=((-38R-74G+112B+128)>>8)+128, Cr=((112R-94G-18B+128)>>8)+128, using an arithmetic shift and clamping to 0..255. With conversion off, the output is {R,G,B}.
- R7: While `pix_valid` is high and `pix_ready` is low, `pix_valid` and `pix_data` hold. No input word is lost or duplicated under any stall pattern.
- R8: In progressive mode, each `hsync` cycle raises `fetch_req` for one cycle on the next clock. `fetch_addr` equals base for the first line after vsync and advances by stride for each further line.
- R9: In interlaced mode, the first line address is base when `field` is 0 at vsync and base+stride when it is 1. Each further line advances by twice the stride.
- R10: A `vsync` drops any pixel waiting at the output and any leftover bytes of an incomplete pixel. The next frame starts from a fresh word.
- R11: While the working configuration is disabled, `word_ready`, `pix_valid` and `fetch_req` stay low regardless of `hsync` and input words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index |
| cfg_wdata | input | 32 | Register write data |
| vsync | input | 1 | Frame start strobe, commits configuration |
| hsync | input | 1 | Line start strobe, requests a line address |
| field | input | 1 | Field flag sampled at vsync (1 = odd field) |
| word_valid | input | 1 | Framebuffer word available |
| word_ready | output | 1 | Block accepts a framebuffer word |
| word_data | input | 32 | Framebuffer word |
| fetch_req | output | 1 | One-cycle line fetch request |
| fetch_addr | output | ADDR_W | Byte address of the requested line |
| pix_valid | output | 1 | Output pixel valid |
| pix_ready | input | 1 | Downstream accepts the pixel |
| pix_data | output | 24 | Pixel, {R,G,B} or {Y,Cb,Cr} |

## Verification
A wrong byte count in the assembly buffer is visible at the ports on the very next pixel. The pixel shows shifted channels, or a word is repeated or skipped, so the packed 24-bit case, where pixels straddle words, exposes it within one three-word group. A line pointer that was loaded or stepped wrongly shows up in `fetch_addr` on the first or second hsync after vsync. A configuration that leaked through before vsync appears as an early change of `word_ready` or of the pixel format, one cycle after the write. Stalling the output on a repeating pattern brings out any loss of hold or loss of a word within a few pixels.

// File: rtl/osd_pkg.sv
package osd_pkg;

   typedef enum logic [1:0] {
      FMT_RGB565 = 2'd0,
      FMT_RGB888 = 2'd1,
      FMT_XRGB   = 2'd2,
      FMT_XRGB_B = 2'd3
   } osd_fmt_e;

   typedef struct packed {
      osd_fmt_e fmt;
      logic     csc;
      logic     ilace;
      logic     en;
   } osd_ctrl_t;

   // bytes consumed per pixel for a stored format
   function automatic logic [2:0] osd_bytes_per_px(input osd_fmt_e f);
      case (f)
         FMT_RGB565: osd_bytes_per_px = 3'd2;
         FMT_RGB888: osd_bytes_per_px = 3'd3;
         default:    osd_bytes_per_px = 3'd4;
      endcase
   endfunction

   // widen a 5:6:5 pixel to 8:8:8 by bit replication
   function automatic logic [23:0] osd_widen565(input logic [15:0] p);
      osd_widen565 = {p[15:11], p[15:13], p[10:5], p[10:9], p[4:0], p[4:2]};
   endfunction

   function automatic osd_ctrl_t osd_decode_ctrl(input logic [31:0] w);
      osd_ctrl_t c;
      c.en    = w[0];
      c.ilace = w[1];
      c.csc   = w[2];
      c.fmt   = osd_fmt_e'(w[5:4]);
      osd_decode_ctrl = c;
   endfunction

endpackage

// File: rtl/osd_cfg_shadow.sv
module osd_cfg_shadow
   import osd_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int STRIDE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [1:0]          addr,
   input  logic [31:0]         wdata,
   input  logic                vsync,
   output osd_ctrl_t           pend_ctrl,
   output logic [ADDR_W-1:0]   pend_base,
   output logic [STRIDE_W-1:0] pend_stride,
   output osd_ctrl_t           act_ctrl,
   output logic [ADDR_W-1:0]   act_base,
   output logic [STRIDE_W-1:0] act_stride
);

   localparam int REG_CTRL   = 0;
   localparam int REG_BASE   = 1;
   localparam int REG_STRIDE = 2;

   generate
      if (ADDR_W > 32 || STRIDE_W > 32) begin : g_bad_width
         $error("osd_cfg_shadow: fields must fit a 32-bit write");
      end
   endgenerate

   // pending copy: any write, any time
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_ctrl   <= '0;
         pend_base   <= '0;
         pend_stride <= '0;
      end else if (we) begin
         case (int'(addr))
            REG_CTRL:   pend_ctrl   <= osd_decode_ctrl(wdata);
            REG_BASE:   pend_base   <= wdata[ADDR_W-1:0];
            REG_STRIDE: pend_stride <= wdata[STRIDE_W-1:0];
            default: ;
         endcase
      end
   end

   // working copy: loads only at vsync
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_ctrl   <= '0;
         act_base   <= '0;
         act_stride <= '0;
      end else if (vsync) begin
         act_ctrl   <= pend_ctrl;
         act_base   <= pend_base;
         act_stride <= pend_stride;
      end
   end

   assert_commit_at_vsync_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !vsync |=> ($stable(act_ctrl) && $stable(act_base) && $stable(act_stride)));

   assert_off_after_reset_R1: assert property (@(posedge clk)
      $past(!rst_n) |-> !act_ctrl.en);

endmodule

// File: rtl/osd_line_addr.sv
module osd_line_addr #(
   parameter int ADDR_W   = 32,
   parameter int STRIDE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                vsync,
   input  logic                hsync,
   input  logic                field,
   input  logic                pend_ilace,
   input  logic [ADDR_W-1:0]   pend_base,
   input  logic [STRIDE_W-1:0] pend_stride,
   input  logic                act_en,
   input  logic                act_ilace,
   input  logic [STRIDE_W-1:0] act_stride,
   output logic                fetch_req,
   output logic [ADDR_W-1:0]   fetch_addr
);

   localparam int EXT_W = ADDR_W - STRIDE_W;

   generate
      if (STRIDE_W >= ADDR_W) begin : g_bad_stride
         $error("osd_line_addr: stride must be narrower than the address");
      end
   endgenerate

   logic [ADDR_W-1:0] row_q;
   logic [ADDR_W-1:0] pend_stride_x, act_stride_x, step;

   assign pend_stride_x = {{EXT_W{1'b0}}, pend_stride};
   assign act_stride_x  = {{EXT_W{1'b0}}, act_stride};
   assign step          = act_ilace ? (act_stride_x << 1) : act_stride_x;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_q      <= '0;
         fetch_req  <= 1'b0;
         fetch_addr <= '0;
      end else if (vsync) begin
         row_q     <= pend_base + ((pend_ilace && field) ? pend_stride_x : '0);
         fetch_req <= 1'b0;
      end else if (hsync && act_en) begin
         fetch_req  <= 1'b1;
         fetch_addr <= row_q;
         row_q      <= row_q + step;
      end else begin
         fetch_req <= 1'b0;
      end
   end

   assert_req_follows_hsync_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> ($past(hsync) && !$past(vsync)));

   assert_req_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !hsync) |=> !fetch_req);

endmodule

// File: rtl/osd_byte_unpack.sv
module osd_byte_unpack
   import osd_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int BUF_BYTES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              en,
   input  osd_fmt_e          fmt,
   input  logic              word_valid,
   output logic              word_ready,
   input  logic [WORD_W-1:0] word_data,
   output logic              px_valid,
   input  logic              px_take,
   output logic [23:0]       px_rgb
);

   localparam int WORD_BYTES = WORD_W / 8;
   localparam int BUF_W      = BUF_BYTES * 8;
   localparam int CNT_W      = $clog2(BUF_BYTES + 1);
   localparam int ROOM       = BUF_BYTES - WORD_BYTES;

   generate
      if (BUF_BYTES < 2 * WORD_BYTES) begin : g_bad_buf
         $error("osd_byte_unpack: buffer must hold two words");
      end
   endgenerate

   logic [BUF_W-1:0] buf_q, shifted, word_x;
   logic [CNT_W-1:0] cnt_q, bpp, ntake, cnt_after;
   logic             accept;

   assign bpp        = CNT_W'(osd_bytes_per_px(fmt));
   assign word_ready = en && (cnt_q <= CNT_W'(ROOM));
   assign accept     = word_valid && word_ready;
   assign px_valid   = en && (cnt_q >= bpp);
   assign ntake      = (px_take && px_valid) ? bpp : '0;
   assign cnt_after  = cnt_q - ntake;
   assign shifted    = buf_q >> {ntake, 3'b000};
   assign word_x     = {{(BUF_W-WORD_W){1'b0}}, word_data};

   // pixel extraction from the oldest bytes
   always_comb begin
      if (fmt == FMT_RGB565) px_rgb = osd_widen565(buf_q[15:0]);
      else                   px_rgb = {buf_q[23:16], buf_q[15:8], buf_q[7:0]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         buf_q <= '0;
         cnt_q <= '0;
      end else begin
         if (accept) begin
            buf_q <= shifted | (word_x << {cnt_after, 3'b000});
            cnt_q <= cnt_after + CNT_W'(WORD_BYTES);
         end else begin
            buf_q <= shifted;
            cnt_q <= cnt_after;
         end
      end
   end

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(BUF_BYTES));

   assert_byte_accounting_R7: assert property (@(posedge clk) disable iff (!rst_n || flush)
      (accept && !(px_take && px_valid)) |=> (cnt_q == $past(cnt_q) + CNT_W'(WORD_BYTES)));

   assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (cnt_q == '0));

endmodule

// File: rtl/osd_csc.sv
module osd_csc (
   input  logic [23:0] rgb,
   output logic [23:0] ycc
);

   localparam int ACC_W = 20;

   function automatic logic [7:0] clamp8(input logic signed [ACC_W-1:0] v);
      if (v < 0)         clamp8 = 8'd0;
      else if (v > 255)  clamp8 = 8'd255;
      else               clamp8 = v[7:0];
   endfunction

   logic signed [ACC_W-1:0] r, g, b;
   logic signed [ACC_W-1:0] y_acc, cb_acc, cr_acc;

   assign r = $signed({{(ACC_W-8){1'b0}}, rgb[23:16]});
   assign g = $signed({{(ACC_W-8){1'b0}}, rgb[15:8]});
   assign b = $signed({{(ACC_W-8){1'b0}}, rgb[7:0]});

   assign y_acc  = ((20'sd66 * r + 20'sd129 * g + 20'sd25 * b + 20'sd128) >>> 8) + 20'sd16;
   assign cb_acc = ((20'sd112 * b - 20'sd38 * r - 20'sd74 * g + 20'sd128) >>> 8) + 20'sd128;
   assign cr_acc = ((20'sd112 * r - 20'sd94 * g - 20'sd18 * b + 20'sd128) >>> 8) + 20'sd128;

   assign ycc = {clamp8(y_acc), clamp8(cb_acc), clamp8(cr_acc)};

   always_comb begin
      assert_luma_range_R6: assert (ycc[23:16] >= 8'd16 && ycc[23:16] <= 8'd235);
   end

endmodule

// File: rtl/osd_scanout.sv
module osd_scanout
   import osd_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int ADDR_W    = 32,
   parameter int STRIDE_W  = 16,
   parameter int BUF_BYTES = 8,
   parameter bit CSC_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic              vsync,
   input  logic              hsync,
   input  logic              field,
   input  logic              word_valid,
   output logic              word_ready,
   input  logic [WORD_W-1:0] word_data,
   output logic              fetch_req,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic              pix_valid,
   input  logic              pix_ready,
   output logic [23:0]       pix_data
);

   generate
      if (WORD_W != 32) begin : g_bad_word
         $error("osd_scanout: word width must be 32");
      end
   endgenerate

   osd_ctrl_t           pend_ctrl, act_ctrl;
   logic [ADDR_W-1:0]   pend_base, act_base;
   logic [STRIDE_W-1:0] pend_stride, act_stride;

   osd_cfg_shadow #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .vsync(vsync),
      .pend_ctrl(pend_ctrl), .pend_base(pend_base), .pend_stride(pend_stride),
      .act_ctrl(act_ctrl), .act_base(act_base), .act_stride(act_stride)
   );

   osd_line_addr #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) u_line (
      .clk(clk), .rst_n(rst_n), .vsync(vsync), .hsync(hsync), .field(field),
      .pend_ilace(pend_ctrl.ilace), .pend_base(pend_base), .pend_stride(pend_stride),
      .act_en(act_ctrl.en), .act_ilace(act_ctrl.ilace), .act_stride(act_stride),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr)
   );

   logic        px_valid, px_take, advance;
   logic [23:0] px_rgb, px_out;

   assign advance = !pix_valid || pix_ready;
   assign px_take = px_valid && advance && !vsync;

   osd_byte_unpack #(.WORD_W(WORD_W), .BUF_BYTES(BUF_BYTES)) u_unpack (
      .clk(clk), .rst_n(rst_n), .flush(vsync), .en(act_ctrl.en), .fmt(act_ctrl.fmt),
      .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
      .px_valid(px_valid), .px_take(px_take), .px_rgb(px_rgb)
   );

   generate
      if (CSC_EN) begin : g_csc
         logic [23:0] ycc;
         osd_csc u_csc (.rgb(px_rgb), .ycc(ycc));
         assign px_out = act_ctrl.csc ? ycc : px_rgb;
      end else begin : g_no_csc
         assign px_out = px_rgb;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || vsync) begin
         pix_valid <= 1'b0;
         pix_data  <= '0;
      end else if (advance) begin
         pix_valid <= px_take;
         if (px_take) pix_data <= px_out;
      end
   end

   assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n || vsync)
      (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data)));

   assert_idle_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !act_ctrl.en |-> (!pix_valid && !word_ready && !fetch_req));

   assert_flush_output_R10: assert property (@(posedge clk) disable iff (!rst_n)
      vsync |=> !pix_valid);

endmodule

// File: tb/tb_osd_scanout.sv
module tb_osd_scanout;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        vsync = 1'b0, hsync = 1'b0, field = 1'b0;
   logic        word_valid = 1'b0;
   logic        word_ready;
   logic [31:0] word_data = '0;
   logic        fetch_req;
   logic [31:0] fetch_addr;
   logic        pix_valid;
   logic        pix_ready = 1'b0;
   logic [23:0] pix_data;

   int checks = 0, failures = 0;
   logic [31:0] wq [0:15];
   logic [23:0] got [0:15];

   always #2.5 clk = ~clk;

   osd_scanout dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .vsync(vsync), .hsync(hsync), .field(field),
      .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ctrl_word(input bit en, input bit il, input bit cs, input int fmt);
      return 32'(en) | (32'(il) << 1) | (32'(cs) << 2) | (32'(fmt) << 4);
   endfunction

   function automatic logic [7:0] sat(input int v);
      if (v < 0) return 8'd0;
      if (v > 255) return 8'd255;
      return v[7:0];
   endfunction

   // studio-range conversion model written from R6
   function automatic logic [23:0] to_ycc(input logic [23:0] p);
      int r = int'(p[23:16]), g = int'(p[15:8]), b = int'(p[7:0]);
      int y  = ((66*r + 129*g + 25*b + 128) >>> 8) + 16;
      int cb = ((-38*r - 74*g + 112*b + 128) >>> 8) + 128;
      int cr = ((112*r - 94*g - 18*b + 128) >>> 8) + 128;
      return {sat(y), sat(cb), sat(cr)};
   endfunction

   function automatic logic [23:0] widen(input logic [15:0] p);
      logic [4:0] r5 = p[15:11];
      logic [5:0] g6 = p[10:5];
      logic [4:0] b5 = p[4:0];
      return {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]};
   endfunction

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic frame(input bit f);
      @(negedge clk); vsync = 1'b1; field = f;
      @(negedge clk); vsync = 1'b0;
   endtask

   task automatic push(input int n);
      @(negedge clk);
      for (int i = 0; i < n; i++) begin
         word_valid = 1'b1; word_data = wq[i];
         while (!word_ready) @(negedge clk);
         @(negedge clk);
      end
      word_valid = 1'b0;
   endtask

   task automatic collect(input int n, input bit stall);
      int k = 0, cyc = 0;
      bit held_v = 1'b0;
      logic [23:0] held = '0;
      while (k < n) begin
         @(negedge clk);
         if (held_v) check(pix_valid && pix_data == held, "R7 hold", {7'd0, pix_valid, pix_data}, {8'd1, held});
         pix_ready = !(stall && (cyc % 3 != 2));
         cyc++;
         if (pix_valid && pix_ready) begin got[k] = pix_data; k++; held_v = 1'b0; end
         else begin held_v = pix_valid; held = pix_data; end
      end
      @(negedge clk); pix_ready = 1'b0;
   endtask

   task automatic line_check(input logic [31:0] exp, input string req);
      @(negedge clk); hsync = 1'b1;
      @(negedge clk); hsync = 1'b0;
      check(fetch_req == 1'b1 && fetch_addr == exp, req, fetch_addr, exp);
   endtask

   task automatic t_reset;
      check(pix_valid == 1'b0, "R1 pix_valid", 32'(pix_valid), 0);
      check(word_ready == 1'b0, "R1 word_ready", 32'(word_ready), 0);
      check(fetch_req == 1'b0, "R1 fetch_req", 32'(fetch_req), 0);
   endtask

   task automatic t_rgb565;
      logic [15:0] h [0:3];
      h[0] = 16'h001F; h[1] = 16'hF800; h[2] = 16'h8410; h[3] = 16'h07E0;
      wr(2'd0, ctrl_word(1, 0, 0, 0));
      @(negedge clk);
      check(word_ready == 1'b0, "R2 pending only", 32'(word_ready), 0);
      frame(0);
      check(word_ready == 1'b1, "R2 commit", 32'(word_ready), 1);
      wq[0] = {h[1], h[0]}; wq[1] = {h[3], h[2]};
      fork push(2); collect(4, 1'b0); join
      for (int i = 0; i < 4; i++) check(got[i] == widen(h[i]), "R3 565", 32'(got[i]), 32'(widen(h[i])));
   endtask

   task automatic t_rgb888;
      logic [23:0] p [0:3];
      logic [7:0]  b [0:11];
      p[0] = 24'h112233; p[1] = 24'hA0B0C0; p[2] = 24'h010203; p[3] = 24'hFEDCBA;
      for (int i = 0; i < 4; i++) begin
         b[3*i] = p[i][7:0]; b[3*i+1] = p[i][15:8]; b[3*i+2] = p[i][23:16];
      end
      for (int i = 0; i < 3; i++) wq[i] = {b[4*i+3], b[4*i+2], b[4*i+1], b[4*i]};
      wr(2'd0, ctrl_word(1, 0, 0, 1));
      frame(0);
      fork push(3); collect(4, 1'b1); join
      for (int i = 0; i < 4; i++) check(got[i] == p[i], "R4 888", 32'(got[i]), 32'(p[i]));
   endtask

   task automatic t_xrgb(input int fmt);
      for (int i = 0; i < 6; i++) wq[i] = {8'(8'hA5 + i*37), 8'(i*40), 8'(255 - i*13), 8'(i*7 + 3)};
      wr(2'd0, ctrl_word(1, 0, 0, fmt));
      frame(0);
      fork push(6); collect(6, 1'b1); join
      for (int i = 0; i < 6; i++) check(got[i] == wq[i][23:0], "R5 xrgb top byte ignored", 32'(got[i]), {8'd0, wq[i][23:0]});
   endtask

   task automatic t_csc;
      wq[0] = 32'h00FFFFFF; wq[1] = 32'h00FF0000; wq[2] = 32'h00000000;
      wq[3] = 32'h000000FF; wq[4] = 32'h0000FF00; wq[5] = 32'h00336699;
      wr(2'd0, ctrl_word(1, 0, 1, 2));
      frame(0);
      fork push(6); collect(6, 1'b1); join
      check(got[0] == 24'hEB8080, "R6 white", 32'(got[0]), 32'h00EB8080);
      for (int i = 1; i < 6; i++) check(got[i] == to_ycc(wq[i][23:0]), "R6 csc", 32'(got[i]), 32'(to_ycc(wq[i][23:0])));
   endtask

   task automatic t_progressive;
      wr(2'd1, 32'h0000_1000);
      wr(2'd2, 32'h0000_0140);
      wr(2'd0, ctrl_word(1, 0, 0, 2));
      frame(1);
      line_check(32'h1000, "R8 line0");
      line_check(32'h1140, "R8 line1");
      line_check(32'h1280, "R8 line2");
      @(negedge clk);
      check(fetch_req == 1'b0, "R8 single pulse", 32'(fetch_req), 0);
   endtask

   task automatic t_interlaced;
      wr(2'd0, ctrl_word(1, 1, 0, 2));
      frame(1);
      line_check(32'h1140, "R9 odd line0");
      line_check(32'h13C0, "R9 odd line1");
      frame(0);
      line_check(32'h1000, "R9 even line0");
      line_check(32'h1280, "R9 even line1");
   endtask

   task automatic t_last_write_and_edge;
      wr(2'd1, 32'h0000_0111);
      wr(2'd1, 32'h0000_0222);
      wr(2'd0, ctrl_word(1, 0, 0, 2));
      frame(0);
      line_check(32'h0222, "R2 last write wins");
      // write disable in the same cycle as vsync: old pending commits
      @(negedge clk); vsync = 1'b1; cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = ctrl_word(0, 0, 0, 2);
      @(negedge clk); vsync = 1'b0; cfg_we = 1'b0;
      check(word_ready == 1'b1, "R2 same-cycle write deferred", 32'(word_ready), 1);
      wr(2'd3, 32'hFFFF_FFFF);
      frame(0);
      check(word_ready == 1'b0, "R2 applied next vsync", 32'(word_ready), 0);
   endtask

   task automatic t_disabled;
      @(negedge clk); hsync = 1'b1; word_valid = 1'b1; word_data = 32'h00123456; pix_ready = 1'b1;
      @(negedge clk); hsync = 1'b0;
      check(fetch_req == 1'b0, "R11 no fetch", 32'(fetch_req), 0);
      @(negedge clk);
      check(pix_valid == 1'b0 && word_ready == 1'b0, "R11 no pixel", {pix_valid, word_ready}, 0);
      word_valid = 1'b0; pix_ready = 1'b0;
   endtask

   task automatic t_flush;
      wr(2'd0, ctrl_word(1, 0, 0, 1));
      frame(0);
      wq[0] = 32'h44332211;
      push(1);
      repeat (2) @(negedge clk);
      check(pix_valid == 1'b1 && pix_data == 24'h332211, "R10 pixel before flush", {7'd0, pix_valid, pix_data}, 32'h01332211);
      wr(2'd0, ctrl_word(1, 0, 0, 2));
      frame(0);
      check(pix_valid == 1'b0, "R10 output dropped", 32'(pix_valid), 0);
      wq[0] = 32'h00ABCDEF;
      fork push(1); collect(1, 1'b0); join
      check(got[0] == 24'hABCDEF, "R10 leftover byte discarded", 32'(got[0]), 32'h00ABCDEF);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rgb565();
      t_rgb888();
      t_xrgb(2);
      t_xrgb(3);
      t_csc();
      t_progressive();
      t_interlaced();
      t_last_write_and_edge();
      t_disabled();
      t_flush();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule